// File: doc/BRIEF.md
# In-Place Image Pixel Cipher Engine

This block encrypts a square image of 16-bit packed colour pixels that sits in a word-addressed memory, rewriting every word at the address it came from. The image is 24 by 24 words and starts at word address 1024. Each word is scrambled in two steps. The two 4-bit halves of each byte change places, and the two bytes keep their positions. The result is then subtracted from the all-ones word, which inverts every bit.

A single pulse on the start input begins a run. The engine drives a single-port synchronous memory that returns read data one cycle after the address. Each word takes a fixed three-cycle slot: present the address, capture the returned data, then write the cipher word. After the last pixel, the engine writes 0x0000 to word 0xFFF to tell the surrounding system that the image is ready for dumping. It then raises done for one cycle and returns to idle. Because the cipher undoes itself, a second run restores the original image.

Top module: `pixel_cipher_engine`

## Requirements
- R1: While reset is held, and afterwards until start is seen, busy_o, done_o and mem_we_o are all 0.
- R2: A start_i pulse seen in idle makes busy_o go high on the next cycle, with mem_addr_o = 1024 and mem_we_o = 0 in that first busy cycle.
- R3: Each pixel occupies exactly three cycles at one unchanging address: read, wait and write, with mem_we_o high only in the third. Pixel addresses ascend from 1024 to 1599 with no gaps.
- R4: The word written for a pixel is 0xFFFF minus the read word after the nibbles are swapped within each byte (bits [15:12] with [11:8], and [7:4] with [3:0]). For example, 0x1234 becomes 0xDEBC.
- R5: Memory words outside 1024..1599 are never written, apart from the trigger word 0xFFF.
- R6: In the cycle after the write for address 1599, the engine writes 0x0000 to address 0xFFF.
- R7: done_o is high for exactly one cycle, the cycle after the trigger write. In the next cycle busy_o is low.
- R8: start_i has no effect while busy_o is high, including the done cycle.
- R9: A run keeps busy_o high for exactly 576*3+2 = 1730 cycles.
- R10: A start given in the first idle cycle after a run begins a new run. That run encrypts the current memory contents, which restores the original image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request pulse, honoured only in idle |
| busy_o | output | 1 | High from the cycle after start through the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 12 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after its address |
| mem_we_o | output | 1 | Memory write enable |

## Verification
Several faults are visible at the memory port on the next clock. A slip in the sequencer or the capture register produces either a write in the wrong slot of a pixel or a cipher word that does not match the data returned one cycle earlier. A fault in the pixel counter shows at the first pixel boundary it crosses, either as a skipped or repeated address or as a write outside the image window. A miscounted last pixel moves the trigger write and the done pulse away from cycle 1730. The cycle-by-cycle comparison catches that on the cycle it happens.

// File: rtl/pxc_pkg.sv
// Package: shared types for the pixel cipher engine.
// Assumes: nothing beyond SystemVerilog 2017 enums.
package pxc_pkg;

    // Sequencer state; one pixel walks READ -> WAIT -> WRITE.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_WRITE = 3'd3,
        ST_TRIG  = 3'd4,
        ST_DONE  = 3'd5
    } pxc_state_e;

endpackage

// File: rtl/pxc_transform.sv
// Module: pxc_transform
// Purely combinational per-word cipher: exchanges the two nibbles inside
// every byte, then subtracts the swapped word from the all-ones value.
// Assumes: DATA_W is a whole number of bytes.
module pxc_transform #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] plain_i,
    output logic [DATA_W-1:0] cipher_o
);
    localparam int NBYTES = DATA_W / 8;
    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    logic [DATA_W-1:0] swapped;

    // One nibble exchange per byte lane.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign swapped[b*8 +: 4]     = plain_i[b*8+4 +: 4];
        assign swapped[b*8+4 +: 4]   = plain_i[b*8 +: 4];
    end

    // Inversion expressed as subtraction from all ones.
    always_comb begin
        cipher_o = ALL_ONES - swapped;
    end

endmodule

// File: rtl/pxc_index_counter.sv
// Module: pxc_index_counter
// Pixel index counter: cleared at run start, stepped once per pixel,
// flags the final pixel of the image.
// Assumes: clr_i and inc_i are never high together.
module pxc_index_counter #(
    parameter int PIX_N = 576,
    parameter int IDX_W = $clog2(PIX_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PIX_N - 1);

    // Index register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o <= '0;
        end else if (clr_i) begin
            idx_o <= '0;
        end else if (inc_i) begin
            idx_o <= idx_o + IDX_W'(1);
        end
    end

    // Final-pixel flag.
    always_comb begin
        last_o = (idx_o == LAST_IDX);
    end

endmodule

// File: rtl/pxc_sequencer.sv
// Module: pxc_sequencer
// Run controller: accepts start only in idle, walks each pixel through
// read / wait / write, then issues the trigger write and a done cycle.
// Assumes: memory read data is valid the cycle after the address.
module pxc_sequencer
    import pxc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       last_i,
    output pxc_state_e state_o,
    output logic       idx_clr_o,
    output logic       idx_inc_o,
    output logic       cap_en_o
);
    pxc_state_e state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_READ;
            ST_READ:  state_d = ST_WAIT;
            ST_WAIT:  state_d = ST_WRITE;
            ST_WRITE: state_d = last_i ? ST_TRIG : ST_READ;
            ST_TRIG:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Control strobes for the counter and capture register.
    always_comb begin
        state_o   = state_q;
        idx_clr_o = (state_q == ST_IDLE) && start_i;
        idx_inc_o = (state_q == ST_WRITE) && !last_i;
        cap_en_o  = (state_q == ST_WAIT);
    end

endmodule

// File: rtl/pixel_cipher_engine.sv
// Module: pixel_cipher_engine (top)
// Encrypts a rectangular image in place in a single-port synchronous
// memory, three cycles per word, then writes a trigger word and pulses
// done. Assumes one cycle of read latency and read-before-write memory.
module pixel_cipher_engine
    import pxc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 16,
    parameter int IMG_W      = 24,
    parameter int IMG_H      = 24,
    parameter int BASE_ADDR  = 1024,
    parameter int TRIG_ADDR  = 4095,
    parameter int TRIG_VALUE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_we_o
);
    localparam int PIX_N = IMG_W * IMG_H;
    localparam int IDX_W = $clog2(PIX_N);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_ADDR);
    localparam logic [DATA_W-1:0] TRIG_D = DATA_W'(TRIG_VALUE);

    pxc_state_e        state;
    logic              idx_clr, idx_inc, cap_en, last_pix;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] plain_q, cipher;

    pxc_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .last_i    (last_pix),
        .state_o   (state),
        .idx_clr_o (idx_clr),
        .idx_inc_o (idx_inc),
        .cap_en_o  (cap_en)
    );

    pxc_index_counter #(
        .PIX_N (PIX_N),
        .IDX_W (IDX_W)
    ) u_idx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (idx_clr),
        .inc_i  (idx_inc),
        .idx_o  (idx),
        .last_o (last_pix)
    );

    pxc_transform #(
        .DATA_W (DATA_W)
    ) u_xform (
        .plain_i  (plain_q),
        .cipher_o (cipher)
    );

    // Hold the word returned by memory during the wait slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plain_q <= '0;
        end else if (cap_en) begin
            plain_q <= mem_rdata_i;
        end
    end

    // Memory port and handshake outputs decoded from the state.
    always_comb begin
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        mem_we_o    = 1'b0;
        unique case (state)
            ST_READ, ST_WAIT: begin
                mem_addr_o = BASE_A + ADDR_W'(idx);
            end
            ST_WRITE: begin
                mem_addr_o  = BASE_A + ADDR_W'(idx);
                mem_wdata_o = cipher;
                mem_we_o    = 1'b1;
            end
            ST_TRIG: begin
                mem_addr_o  = TRIG_A;
                mem_wdata_o = TRIG_D;
                mem_we_o    = 1'b1;
            end
            default: ;
        endcase
        busy_o = (state != ST_IDLE);
        done_o = (state == ST_DONE);
    end

endmodule

// File: rtl/pxc_checker.sv
// Module: pxc_checker
// Port-level temporal checks for pixel_cipher_engine, bound to the top.
// Assumes: DATA_W is a whole number of bytes.
module pxc_checker #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 16,
    parameter int IMG_W      = 24,
    parameter int IMG_H      = 24,
    parameter int BASE_ADDR  = 1024,
    parameter int TRIG_ADDR  = 4095,
    parameter int TRIG_VALUE = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic [DATA_W-1:0] mem_rdata_i,
    input logic              mem_we_o
);
    localparam int LAST_ADDR = BASE_ADDR + IMG_W * IMG_H - 1;
    localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_ADDR);
    localparam logic [DATA_W-1:0] TRIG_D = DATA_W'(TRIG_VALUE);

    function automatic logic [DATA_W-1:0] expect_word(input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] s;
        for (int b = 0; b < DATA_W / 8; b++) begin
            s[b*8+4 +: 4] = d[b*8 +: 4];
            s[b*8 +: 4]   = d[b*8+4 +: 4];
        end
        return ~s;
    endfunction

    logic img_wr;
    always_comb begin
        img_wr = mem_we_o && (mem_addr_o != TRIG_A);
    end

    // R1: no write or handshake activity during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!mem_we_o && !done_o)
                else $error("reset quiet");
        end
    end

    p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (mem_addr_o == ADDR_W'(BASE_ADDR)) && !mem_we_o);

    p_same_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        img_wr |-> (mem_addr_o == $past(mem_addr_o)) && (mem_addr_o == $past(mem_addr_o, 2))
                   && !$past(mem_we_o) && !$past(mem_we_o, 2));

    p_cipher_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        img_wr |-> mem_wdata_o == expect_word($past(mem_rdata_i)));

    p_write_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        img_wr |-> (int'(mem_addr_o) >= BASE_ADDR) && (int'(mem_addr_o) <= LAST_ADDR));

    p_trig_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && mem_addr_o == TRIG_A) |-> mem_wdata_o == TRIG_D
                                              && $past(mem_addr_o) == ADDR_W'(LAST_ADDR));

    p_done_after_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_we_o) && $past(mem_addr_o) == TRIG_A);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

endmodule

bind pixel_cipher_engine pxc_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .IMG_W      (IMG_W),
    .IMG_H      (IMG_H),
    .BASE_ADDR  (BASE_ADDR),
    .TRIG_ADDR  (TRIG_ADDR),
    .TRIG_VALUE (TRIG_VALUE)
) u_pxc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_we_o    (mem_we_o)
);

// File: tb/test_pixel_cipher_engine.sv
`timescale 1ns/1ps
module test_pixel_cipher_engine;

    localparam int RUN_LEN = 576 * 3 + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, we;
    logic [11:0] addr;
    logic [15:0] wdata, rdata;

    logic [15:0] mem     [4096];
    logic [15:0] ref_mem [4096];
    logic [15:0] orig    [4096];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int k      = -1;
    int busy_cnt = 0;

    always #2.5 clk = ~clk;

    pixel_cipher_engine i_pixel_cipher_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .busy_o      (busy),
        .done_o      (done),
        .mem_addr_o  (addr),
        .mem_wdata_o (wdata),
        .mem_rdata_i (rdata),
        .mem_we_o    (we)
    );

    function automatic logic [15:0] enc(input logic [15:0] d);
        return 16'hFFFF - {d[11:8], d[15:12], d[3:0], d[7:4]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Synchronous memory, one cycle read latency, read before write.
    always @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end

    // Reference model: run position k, shadow memory updated on writes.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            k = -1;
        end else if (k < 0) begin
            if (start) k = 0;
        end else begin
            if (k < 1728 && k % 3 == 2)
                ref_mem[1024 + k / 3] = enc(ref_mem[1024 + k / 3]);
            else if (k == 1728)
                ref_mem[4095] = 16'h0000;
            k++;
            if (k == RUN_LEN) k = -1;
        end
        if (cyc > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            summary();
            $finish;
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (busy) busy_cnt++;
        if (!rst_n || k < 0) begin
            chk("R1 idle busy", busy, 0);
            chk("R1 idle done", done, 0);
            chk("R1 idle we", we, 0);
        end else begin
            chk("R8 busy", busy, 1);
            if (k < 1728) begin
                chk("R3 addr", addr, 1024 + k / 3);
                chk("R3 we slot", we, (k % 3 == 2) ? 1 : 0);
                chk("R7 done early", done, 0);
                if (k % 3 == 2) chk("R4 cipher", wdata, enc(ref_mem[1024 + k / 3]));
            end else if (k == 1728) begin
                chk("R6 trig addr", addr, 12'hFFF);
                chk("R6 trig we", we, 1);
                chk("R6 trig data", wdata, 0);
                chk("R7 done early", done, 0);
            end else begin
                chk("R7 done", done, 1);
                chk("R7 done we", we, 0);
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (k >= 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 16'((i * 40503) ^ 16'h5A5A);
        end
        mem[1024] = 16'h1234;
        mem[1025] = 16'h0000;
        mem[1026] = 16'hF00F;
        mem[1599] = 16'hFFFF;
        for (int i = 0; i < 4096; i++) begin
            ref_mem[i] = mem[i];
            orig[i]    = mem[i];
        end
        start = 1'b1;                       // R1: start held during reset is ignored
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 after reset busy", busy, 0);

        // Run 1 with start pulses thrown in while busy (R8).
        busy_cnt = 0;
        pulse_start();
        chk("R2 first addr", addr, 1024);
        chk("R2 first we", we, 0);
        repeat (100) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        start = 1'b1;                       // R8: start during the done cycle
        @(negedge clk);
        start = 1'b0;
        chk("R8 start in done ignored", busy, 0);
        wait_idle();
        chk("R9 run length", busy_cnt, RUN_LEN);
        chk("R4 word 1024", mem[1024], 16'hDEBC);
        chk("R4 word 1025", mem[1025], 16'hFFFF);
        chk("R4 word 1026", mem[1026], 16'hF00F);
        chk("R4 word 1599", mem[1599], 16'h0000);
        chk("R5 word 1023 untouched", mem[1023], orig[1023]);
        chk("R5 word 1600 untouched", mem[1600], orig[1600]);
        chk("R6 trigger word", mem[4095], 16'h0000);
        begin
            int bad = 0;
            for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) bad++;
            chk("R5 full memory image", bad, 0);
        end

        // Run 2 started in the first idle cycle (R10).
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 restart busy", busy, 1);
        wait_idle();
        begin
            int bad = 0;
            for (int i = 1024; i < 1600; i++) if (mem[i] !== orig[i]) bad++;
            chk("R10 image restored", bad, 0);
        end
        chk("R10 word 1024", mem[1024], 16'h1234);
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule